// File: doc/BRIEF.md
# Dataflow-Triggered Sparse Multiply-Accumulate Tile

This block is the datapath of one processing element in a spatial compute array. A small local memory holds a slice of activation elements, which stays in place across many incoming weights. Nothing runs from a program counter. Work starts when a packet arrives from the fabric, and the packet's operation field picks the action: a multiply-accumulate sweep, a clear of the accumulators, a readout of the accumulators, or a no-op.

A weight packet carries a signed fixed-point weight and an output index. The tile multiplies that weight by each active activation element, one element per cycle. Each product goes into the accumulator for that output row and element position. The weight is held only in the sequencer for the length of the sweep and is never written into local memory. The fabric sends only nonzero weights. A zero weight that does arrive is consumed without taking a compute cycle.

The accumulator bank has NUM_OUT rows of MAX_ELEMS entries, each 40 bits wide. A readout packet streams the active part of the bank onto the output port, one value per cycle. The sequencer has four states:
- ST_IDLE: ready for a packet. It moves to ST_SWEEP on a nonzero weight, to ST_CLEAR on a clear, and to ST_DRAIN on a readout. It stays in ST_IDLE on a zero weight or a no-op.
- ST_SWEEP: runs one element per cycle and returns to ST_IDLE after the last active element.
- ST_CLEAR: lasts one cycle, then returns to ST_IDLE.
- ST_DRAIN: steps through elements inside each row and rows in ascending order, then returns to ST_IDLE after the last element of the last row.

Top module: `sfmac_tile`

## Requirements
- R1: After reset, `pkt_ready` is 1, `out_valid` is 0, the active element count is MAX_ELEMS (16), and every accumulator reads 0.
- R2: A packet with `pkt_op` = 0 and a nonzero `pkt_data` w adds the signed product w·a[e] into accumulator (`pkt_index`, e) for every e below the active count. The sum wraps modulo 2^40. All other accumulators are left unchanged.
- R3: After a nonzero weight is accepted, `pkt_ready` stays low for exactly N cycles, where N is the active count. This is one element per cycle.
- R4: A weight packet (`pkt_op` = 0) whose `pkt_data` is 0 is accepted and changes no accumulator. `pkt_ready` is high again in the next cycle.
- R5: A packet with `pkt_op` = 1 zeroes every accumulator. `pkt_ready` is low for exactly one cycle afterwards.
- R6: A packet with `pkt_op` = 2 streams NUM_OUT·N values, starting in the cycle after acceptance, one per cycle with `out_valid` high. For each row in ascending order it sends elements 0 to N−1. `out_index` and `out_elem` name the entry. `pkt_ready` is low during the stream, and `out_valid` falls after the last value.
- R7: Activation writes (`act_wr_en`) and count writes (`cfg_wr_en`) are ignored while `pkt_ready` is low.
- R8: A count write stores `cfg_count` clamped to the range 1 to MAX_ELEMS. A value of 0 becomes 1, and a value above 16 becomes 16.
- R9: A packet with `pkt_op` = 3 is accepted as a no-op. It changes no accumulator, and `pkt_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_wr_en | input | 1 | Write one activation element |
| act_wr_addr | input | 4 | Activation element address |
| act_wr_data | input | 16 | Signed activation value |
| cfg_wr_en | input | 1 | Write the active element count |
| cfg_count | input | 5 | Requested active count (clamped) |
| pkt_valid | input | 1 | Fabric packet present |
| pkt_op | input | 2 | 0 weight, 1 clear, 2 readout, 3 no-op |
| pkt_index | input | 2 | Output row fed by a weight |
| pkt_data | input | 16 | Signed weight value |
| pkt_ready | output | 1 | Tile accepts a packet this cycle |
| out_valid | output | 1 | Readout value present |
| out_index | output | 2 | Row of the readout value |
| out_elem | output | 4 | Element of the readout value |
| out_data | output | 40 | Accumulator value |

## Verification
Directed extremes check that sign extension and wrap are correct. One case is the most negative weight multiplied by the most negative activation; another is the largest positive value multiplied by the most negative. A weight of one turns a readout into a copy of the activation memory, which makes any write that should have been ignored visible at the ports. Random nonzero weights sent to random rows, at several active counts, show whether the row selection and the element bound are right. Zero weights, no-ops and a clear followed by a readout separate "accepted with no effect" from "accepted and acted on".

// File: rtl/sfmac_pkg.sv
package sfmac_pkg;
    typedef enum logic [1:0] {
        OP_FMAC  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_READ  = 2'd2,
        OP_NOP   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SWEEP,
        ST_CLEAR,
        ST_DRAIN
    } state_e;

    typedef struct packed {
        logic fmac;
        logic clear;
        logic read;
    } cmd_t;
endpackage

// File: rtl/sfmac_act_mem.sv
module sfmac_act_mem #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [DEPTH-1:0][W-1:0] mem_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (wr_en && wr_addr == AW'(i))
                mem_q[i] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/sfmac_decode.sv
module sfmac_decode #(
    parameter int ACT_W = 16
) (
    input  logic                 accept,
    input  logic [1:0]           op,
    input  logic [ACT_W-1:0]     data,
    output sfmac_pkg::cmd_t      cmd
);
    import sfmac_pkg::*;

    always_comb begin
        cmd = '0;
        if (accept) begin
            unique case (op_e'(op))
                OP_FMAC:  cmd.fmac  = (data != '0);
                OP_CLEAR: cmd.clear = 1'b1;
                OP_READ:  cmd.read  = 1'b1;
                OP_NOP:   cmd       = '0;
                default:  cmd       = '0;
            endcase
        end
    end

    // R9: at most one command launched per packet
    always_comb begin
        assert_onehot_cmd_R9: assert ($onehot0(cmd));
    end
endmodule

// File: rtl/sfmac_ctrl.sv
module sfmac_ctrl #(
    parameter int MAX_ELEMS = 16,
    parameter int NUM_OUT   = 4,
    parameter int ACT_W     = 16,
    localparam int EW = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1,
    localparam int CW = $clog2(MAX_ELEMS + 1),
    localparam int OW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sfmac_pkg::cmd_t    cmd,
    input  logic [OW-1:0]      pkt_index,
    input  logic [ACT_W-1:0]   pkt_data,
    input  logic [CW-1:0]      count,
    output logic               idle,
    output logic               add_en,
    output logic               clr_en,
    output logic               rd_valid,
    output logic [OW-1:0]      row,
    output logic [EW-1:0]      elem,
    output logic [ACT_W-1:0]   weight
);
    import sfmac_pkg::*;

    state_e           state_q, state_n;
    logic [OW-1:0]    row_q, row_n;
    logic [EW-1:0]    elem_q, elem_n;
    logic [ACT_W-1:0] w_q, w_n;
    logic             elem_last, row_last;

    assign elem_last = (CW'(elem_q) == count - CW'(1));
    assign row_last  = (row_q == OW'(NUM_OUT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            elem_q  <= '0;
            w_q     <= '0;
        end else begin
            state_q <= state_n;
            row_q   <= row_n;
            elem_q  <= elem_n;
            w_q     <= w_n;
        end
    end

    always_comb begin
        state_n = state_q;
        row_n   = row_q;
        elem_n  = elem_q;
        w_n     = w_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd.fmac) begin
                    state_n = ST_SWEEP;
                    row_n   = pkt_index;
                    elem_n  = '0;
                    w_n     = pkt_data;
                end else if (cmd.clear) begin
                    state_n = ST_CLEAR;
                end else if (cmd.read) begin
                    state_n = ST_DRAIN;
                    row_n   = '0;
                    elem_n  = '0;
                end
            end
            ST_SWEEP: begin
                if (elem_last) state_n = ST_IDLE;
                else           elem_n  = elem_q + EW'(1);
            end
            ST_CLEAR: state_n = ST_IDLE;
            ST_DRAIN: begin
                if (elem_last) begin
                    elem_n = '0;
                    if (row_last) state_n = ST_IDLE;
                    else          row_n   = row_q + OW'(1);
                end else begin
                    elem_n = elem_q + EW'(1);
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        idle     = (state_q == ST_IDLE);
        add_en   = (state_q == ST_SWEEP);
        clr_en   = (state_q == ST_CLEAR);
        rd_valid = (state_q == ST_DRAIN);
        row      = row_q;
        elem     = elem_q;
        weight   = w_q;
    end

    // R3: a launched weight starts its sweep at element zero
    assert_sweep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.fmac |=> (state_q == ST_SWEEP && elem_q == '0));
    // R3: the sweep never passes the active count
    assert_sweep_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP) |-> (CW'(elem_q) < count));
    // R6: the stream is unbroken until the final entry
    assert_drain_unbroken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !(elem_last && row_last)) |=> (state_q == ST_DRAIN));
    // R5: clear lasts one cycle
    assert_clear_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sfmac_acc_bank.sv
module sfmac_acc_bank #(
    parameter int MAX_ELEMS = 16,
    parameter int NUM_OUT   = 4,
    parameter int ACC_W     = 40,
    localparam int EW = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1,
    localparam int OW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
    localparam int N  = NUM_OUT * MAX_ELEMS,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [OW-1:0]    row,
    input  logic [EW-1:0]    elem,
    input  logic [ACC_W-1:0] add_val,
    output logic [ACC_W-1:0] rd_data
);
    logic [N-1:0][ACC_W-1:0] acc_q;
    logic [AW-1:0]           sel;

    assign sel = AW'(row) * AW'(MAX_ELEMS) + AW'(elem);

    for (genvar i = 0; i < N; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                acc_q[i] <= '0;
            else if (add_en && sel == AW'(i))
                acc_q[i] <= acc_q[i] + add_val;
        end
    end

    assign rd_data = acc_q[sel];

    // R5: a clear leaves every accumulator at zero
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));
    // R2: the selected accumulator grows by exactly the product
    assert_accumulate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr) |=> (acc_q[$past(sel)] == $past(rd_data) + $past(add_val)));
endmodule

// File: rtl/sfmac_tile.sv
module sfmac_tile #(
    parameter int ACT_W     = 16,
    parameter int ACC_W     = 40,
    parameter int MAX_ELEMS = 16,
    parameter int NUM_OUT   = 4,
    localparam int EW = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1,
    localparam int CW = $clog2(MAX_ELEMS + 1),
    localparam int OW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_wr_en,
    input  logic [EW-1:0]    act_wr_addr,
    input  logic [ACT_W-1:0] act_wr_data,
    input  logic             cfg_wr_en,
    input  logic [CW-1:0]    cfg_count,
    input  logic             pkt_valid,
    input  logic [1:0]       pkt_op,
    input  logic [OW-1:0]    pkt_index,
    input  logic [ACT_W-1:0] pkt_data,
    output logic             pkt_ready,
    output logic             out_valid,
    output logic [OW-1:0]    out_index,
    output logic [EW-1:0]    out_elem,
    output logic [ACC_W-1:0] out_data
);
    import sfmac_pkg::*;

    logic                      idle, add_en, clr_en, rd_valid, accept;
    logic [OW-1:0]             row;
    logic [EW-1:0]             elem;
    logic [ACT_W-1:0]          weight, act_rd;
    logic signed [2*ACT_W-1:0] prod;
    logic [ACC_W-1:0]          add_val, acc_rd;
    logic [CW-1:0]             count_q;
    cmd_t                      cmd;

    assign accept    = pkt_valid && idle;
    assign pkt_ready = idle;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= CW'(MAX_ELEMS);
        else if (cfg_wr_en && idle) begin
            if (cfg_count == '0)                   count_q <= CW'(1);
            else if (cfg_count > CW'(MAX_ELEMS))   count_q <= CW'(MAX_ELEMS);
            else                                   count_q <= cfg_count;
        end
    end

    sfmac_act_mem #(.DEPTH(MAX_ELEMS), .W(ACT_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (act_wr_en && idle),
        .wr_addr (act_wr_addr),
        .wr_data (act_wr_data),
        .rd_addr (elem),
        .rd_data (act_rd)
    );

    sfmac_decode #(.ACT_W(ACT_W)) u_dec (
        .accept (accept),
        .op     (pkt_op),
        .data   (pkt_data),
        .cmd    (cmd)
    );

    sfmac_ctrl #(.MAX_ELEMS(MAX_ELEMS), .NUM_OUT(NUM_OUT), .ACT_W(ACT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .pkt_index (pkt_index),
        .pkt_data  (pkt_data),
        .count     (count_q),
        .idle      (idle),
        .add_en    (add_en),
        .clr_en    (clr_en),
        .rd_valid  (rd_valid),
        .row       (row),
        .elem      (elem),
        .weight    (weight)
    );

    assign prod    = $signed(weight) * $signed(act_rd);
    assign add_val = ACC_W'(prod);

    sfmac_acc_bank #(.MAX_ELEMS(MAX_ELEMS), .NUM_OUT(NUM_OUT), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_en),
        .add_en  (add_en),
        .row     (row),
        .elem    (elem),
        .add_val (add_val),
        .rd_data (acc_rd)
    );

    assign out_valid = rd_valid;
    assign out_index = row;
    assign out_elem  = elem;
    assign out_data  = rd_valid ? acc_rd : '0;

    // R4: a zero weight leaves the tile ready
    assert_zero_weight_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pkt_op == 2'd0 && pkt_data == '0) |=> pkt_ready);
    // R9: a no-op leaves the tile ready
    assert_nop_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pkt_op == 2'd3) |=> pkt_ready);
    // R7: memory and count hold while busy
    assert_busy_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_ready |=> $stable(u_mem.mem_q));
    assert_busy_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_ready |=> $stable(count_q));
    // R8: count stays within range
    assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q >= CW'(1)) && (count_q <= CW'(MAX_ELEMS)));
endmodule

// File: tb/sfmac_tile_bench.sv
module sfmac_tile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_wr_en = 1'b0;
    logic [3:0]  act_wr_addr = '0;
    logic [15:0] act_wr_data = '0;
    logic        cfg_wr_en = 1'b0;
    logic [4:0]  cfg_count = '0;
    logic        pkt_valid = 1'b0;
    logic [1:0]  pkt_op = '0;
    logic [1:0]  pkt_index = '0;
    logic [15:0] pkt_data = '0;
    logic        pkt_ready, out_valid;
    logic [1:0]  out_index;
    logic [3:0]  out_elem;
    logic [39:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    shortint     act_m [16];
    logic [39:0] acc_m [4][16];
    int          cnt_m;

    always #5 clk = ~clk;

    sfmac_tile u_sfmac_tile (
        .clk(clk), .rst_n(rst_n),
        .act_wr_en(act_wr_en), .act_wr_addr(act_wr_addr), .act_wr_data(act_wr_data),
        .cfg_wr_en(cfg_wr_en), .cfg_count(cfg_count),
        .pkt_valid(pkt_valid), .pkt_op(pkt_op), .pkt_index(pkt_index), .pkt_data(pkt_data),
        .pkt_ready(pkt_ready), .out_valid(out_valid), .out_index(out_index),
        .out_elem(out_elem), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp_cnt(input int v);
        if (v == 0) return 1;
        if (v > 16) return 16;
        return v;
    endfunction

    function automatic void model_weight(input int idx, input shortint w);
        for (int e = 0; e < cnt_m; e++) begin
            longint p = longint'(w) * longint'(act_m[e]);
            acc_m[idx][e] = acc_m[idx][e] + p[39:0];
        end
    endfunction

    function automatic void model_clear();
        for (int r = 0; r < 4; r++)
            for (int e = 0; e < 16; e++) acc_m[r][e] = '0;
    endfunction

    task automatic send(input logic [1:0] op, input int idx, input int data);
        @(negedge clk);
        while (!pkt_ready) @(negedge clk);
        pkt_valid = 1'b1; pkt_op = op; pkt_index = idx[1:0]; pkt_data = data[15:0];
        @(posedge clk); #1;
        pkt_valid = 1'b0;
    endtask

    task automatic busy_len(output int k);
        k = 0;
        @(negedge clk);
        while (!pkt_ready && k < 200) begin
            k++;
            @(negedge clk);
        end
    endtask

    task automatic write_act(input int a, input shortint v);
        @(negedge clk);
        act_wr_en = 1'b1; act_wr_addr = a[3:0]; act_wr_data = v;
        @(posedge clk); #1;
        act_wr_en = 1'b0;
        act_m[a] = v;
    endtask

    task automatic write_cnt(input int v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_count = v[4:0];
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
        cnt_m = clamp_cnt(v);
    endtask

    task automatic weight(input int idx, input shortint w, input string req);
        int k;
        send(2'd0, idx, int'(w));
        model_weight(idx, w);
        busy_len(k);
        chk(k == ((w == 0) ? 0 : cnt_m), req, "busy cycles after weight", k, (w == 0) ? 0 : cnt_m);
    endtask

    task automatic readout(input string req);
        send(2'd2, 0, 0);
        for (int r = 0; r < 4; r++) begin
            for (int e = 0; e < cnt_m; e++) begin
                @(negedge clk);
                chk(out_valid === 1'b1 && pkt_ready === 1'b0, "R6", "stream valid/busy", out_valid, 1);
                chk(out_index === r[1:0] && out_elem === e[3:0], "R6", "stream order",
                    longint'(out_index) * 16 + longint'(out_elem), r * 16 + e);
                chk(out_data === acc_m[r][e], req, "accumulator value",
                    longint'(out_data), longint'(acc_m[r][e]));
            end
        end
        @(negedge clk);
        chk(out_valid === 1'b0 && pkt_ready === 1'b1, "R6", "stream end", out_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int k;
        seed = $urandom(32'd2024);
        for (int e = 0; e < 16; e++) act_m[e] = 0;
        model_clear();
        cnt_m = 16;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(pkt_ready === 1'b1, "R1", "ready after reset", pkt_ready, 1);
        chk(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);
        readout("R1");

        // R2: directed extremes
        for (int e = 0; e < 16; e++) write_act(e, shortint'($urandom_range(0, 65535)));
        write_act(0, 16'sh7FFF);
        write_act(5, -16'sd32768);
        weight(3, -16'sd32768, "R3");
        weight(3, -16'sd32768, "R3");
        weight(0, 16'sd1, "R3");
        weight(1, 16'sh7FFF, "R3");
        readout("R2");

        // R4: zero weight has no effect
        weight(2, 16'sd0, "R4");
        readout("R4");

        // R9: no-op has no effect
        send(2'd3, 1, 16'h1234);
        busy_len(k);
        chk(k == 0, "R9", "busy cycles after no-op", k, 0);
        readout("R9");

        // R2: random weights, random rows
        for (int i = 0; i < 40; i++) begin
            shortint w;
            w = shortint'($urandom_range(1, 65535));
            weight($urandom_range(0, 3), w, "R3");
            if (i % 10 == 9) readout("R2");
        end

        // R5: clear
        send(2'd1, 0, 0);
        model_clear();
        busy_len(k);
        chk(k == 1, "R5", "busy cycles after clear", k, 1);
        readout("R5");

        // R8: count clamping
        write_cnt(0);
        weight(2, 16'sd7, "R8");
        readout("R8");
        write_cnt(20);
        weight(1, -16'sd3, "R8");
        readout("R8");
        write_cnt(5);
        for (int i = 0; i < 6; i++)
            weight($urandom_range(0, 3), shortint'($urandom_range(1, 65535)), "R3");
        readout("R2");

        // R7: writes ignored while busy
        send(2'd1, 0, 0);
        model_clear();
        busy_len(k);
        write_cnt(16);
        send(2'd0, 0, 1);
        model_weight(0, 16'sd1);
        @(negedge clk);
        act_wr_en = 1'b1; act_wr_addr = 4'd2; act_wr_data = 16'd1234;
        cfg_wr_en = 1'b1; cfg_count = 5'd3;
        @(posedge clk); @(posedge clk); #1;
        act_wr_en = 1'b0; cfg_wr_en = 1'b0;
        busy_len(k);
        send(2'd0, 1, 1);
        model_weight(1, 16'sd1);
        busy_len(k);
        chk(k == 16, "R7", "count unchanged by busy write", k, 16);
        readout("R7");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule